// File: doc/BRIEF.md
# Presence-Flagged Stream Operator Unit

This block evaluates one dataflow stream operator per reference instant over two input channels, A and B. Each channel carries a data word and a presence flag. An absent sample is marked by a low presence flag and is not simply missing. Each input also has a tick line and an acknowledge line. Both are two-phase, so every transition of either line is one event. An instant is complete once both input ticks have produced an event. The block then computes the result, forwards one tick event on its output channel together with the result's value and presence flag, and closes the instant by toggling both input acknowledges.

A static operator select picks one of four operators:
- **Conditional sub-sampling:** A is kept only where B is a present, true condition.
- **Priority merge:** A is preferred over B.
- **One-instant delay:** returns the previous present value of A.
- **Pass-through:** forwards A unchanged.

The output tick is forwarded on every instant, even when the result is absent. A consumer therefore always sees an instant boundary, and a low presence flag stands in for "no sample".

Top module: `stream_op_unit`

## Requirements
- R1: While `rst` is high (synchronous, active high), no tick or acknowledge toggles. After reset, `y_tick`, `a_ack`, `b_ack` and `y_prs` are all 0.
- R2: An instant closes at the first rising clock edge at which both `a_tick` and `b_tick` have toggled since the previous instant closed. At that edge `y_tick`, `a_ack` and `b_ack` each toggle exactly once.
- R3: While only one of the two input ticks has toggled in the current instant, `y_tick`, `a_ack` and `b_ack` do not change.
- R4: With `mode` = 0 (sub-sampling), `y_prs` = `a_prs` AND `b_prs` AND `b_val[0]`. When `y_prs` is 1, `y_val` equals `a_val`.
- R5: With `mode` = 1 (priority merge), `y_prs` = `a_prs` OR `b_prs`. `y_val` is `a_val` when `a_prs` is 1, and otherwise `b_val`.
- R6: With `mode` = 2 (delay), `y_prs` = `a_prs`. `y_val` is the held value, which is the `a_val` of the latest earlier instant in which `a_prs` was 1, or 0 if there has been no such instant since reset.
- R7: With `mode` = 3 (pass-through), `y_prs` = `a_prs`, and `y_val` equals `a_val` when present.
- R8: The held value used by R6 is loaded on every closed instant in which `a_prs` is 1, in any mode. Channel B never affects it.
- R9: `y_val` and `y_prs` change only at the clock edge where `y_tick` toggles. Both are therefore stable before and after every output tick event.
- R10: An instant whose result is absent still toggles `y_tick`, with `y_prs` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for edge detection and result registers |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operator select: 0 sub-sample, 1 merge, 2 delay, 3 pass |
| a_val | input | DW | Channel A data word |
| a_prs | input | 1 | Channel A presence flag |
| a_tick | input | 1 | Channel A two-phase tick |
| a_ack | output | 1 | Channel A two-phase acknowledge |
| b_val | input | DW | Channel B data word (bit 0 is the condition in mode 0) |
| b_prs | input | 1 | Channel B presence flag |
| b_tick | input | 1 | Channel B two-phase tick |
| b_ack | output | 1 | Channel B two-phase acknowledge |
| y_val | output | DW | Result data word |
| y_prs | output | 1 | Result presence flag |
| y_tick | output | 1 | Result two-phase tick |

## Verification
Inputs change just after a falling edge. The rising edge that follows the later of the two input tick toggles closes the instant. `y_tick`, both acknowledges, `y_prs` and `y_val` all update at that edge, one register stage after the tick, and the bench compares them at the next falling edge. On every falling edge between the first and the last tick toggle of an instant, the bench checks that all three event lines and the result word are unchanged from the previous instant. The held value for the delay operator is tracked in the bench from the presence and data of every earlier instant, independently of the operator in use.

// File: rtl/sopu_pkg.sv
package sopu_pkg;

    typedef enum logic [1:0] {
        OP_WHEN  = 2'd0,
        OP_MERGE = 2'd1,
        OP_DELAY = 2'd2,
        OP_PASS  = 2'd3
    } op_mode_e;

endpackage

// File: rtl/sopu_tick_track.sv
module sopu_tick_track (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    input  logic close,
    output logic arrived,
    output logic ack
);

    typedef struct packed {
        logic seen;
        logic pend;
        logic ack;
    } trk_t;

    trk_t st_d, st_q;
    logic evt;

    always_comb begin
        evt     = tick_in ^ st_q.seen;
        arrived = st_q.pend | evt;
        st_d      = st_q;
        st_d.seen = tick_in;
        if (close) begin
            st_d.pend = 1'b0;
            st_d.ack  = ~st_q.ack;
        end else begin
            st_d.pend = st_q.pend | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ack = st_q.ack;

    // R2
    ack_follows_close_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ack != $past(st_q.ack)) |-> $past(close && arrived));

endmodule

// File: rtl/sopu_op_core.sv
module sopu_op_core
    import sopu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  op_mode_e      op,
    input  logic          fire,
    input  logic [DW-1:0] a_val,
    input  logic          a_prs,
    input  logic [DW-1:0] b_val,
    input  logic          b_prs,
    output logic [DW-1:0] res_val,
    output logic          res_prs
);

    logic [DW-1:0] hold_d, hold_q;
    logic          cond_ok;

    always_comb begin
        hold_d = hold_q;
        if (fire && a_prs) hold_d = a_val;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    always_comb begin
        cond_ok = b_prs & b_val[0];
        res_val = a_val;
        res_prs = a_prs;
        case (op)
            OP_WHEN: begin
                res_prs = a_prs & cond_ok;
                res_val = a_val;
            end
            OP_MERGE: begin
                res_prs = a_prs | b_prs;
                res_val = a_prs ? a_val : b_val;
            end
            OP_DELAY: begin
                res_prs = a_prs;
                res_val = hold_q;
            end
            default: begin
                res_prs = a_prs;
                res_val = a_val;
            end
        endcase
    end

    // R8
    hold_update_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q != $past(hold_q)) |-> $past(fire && a_prs));

endmodule

// File: rtl/stream_op_unit.sv
module stream_op_unit
    import sopu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] a_val,
    input  logic          a_prs,
    input  logic          a_tick,
    output logic          a_ack,
    input  logic [DW-1:0] b_val,
    input  logic          b_prs,
    input  logic          b_tick,
    output logic          b_ack,
    output logic [DW-1:0] y_val,
    output logic          y_prs,
    output logic          y_tick
);

    localparam int NIN = 2;

    typedef struct packed {
        logic          tick;
        logic          prs;
        logic [DW-1:0] val;
    } out_t;

    logic [NIN-1:0] tick_vec, arr_vec, ack_vec;
    logic           fire;
    logic [DW-1:0]  res_val;
    logic           res_prs;
    out_t           out_d, out_q;

    assign tick_vec = {b_tick, a_tick};
    assign fire     = &arr_vec;

    generate
        for (genvar i = 0; i < NIN; i++) begin : g_trk
            sopu_tick_track u_trk (
                .clk     (clk),
                .rst     (rst),
                .tick_in (tick_vec[i]),
                .close   (fire),
                .arrived (arr_vec[i]),
                .ack     (ack_vec[i])
            );
        end
    endgenerate

    sopu_op_core #(.DW(DW)) u_core (
        .clk     (clk),
        .rst     (rst),
        .op      (op_mode_e'(mode)),
        .fire    (fire),
        .a_val   (a_val),
        .a_prs   (a_prs),
        .b_val   (b_val),
        .b_prs   (b_prs),
        .res_val (res_val),
        .res_prs (res_prs)
    );

    always_comb begin
        out_d = out_q;
        if (fire) begin
            out_d.tick = ~out_q.tick;
            out_d.prs  = res_prs;
            out_d.val  = res_prs ? res_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign y_tick = out_q.tick;
    assign y_prs  = out_q.prs;
    assign y_val  = out_q.val;
    assign a_ack  = ack_vec[0];
    assign b_ack  = ack_vec[1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!y_tick && !a_ack && !b_ack && !y_prs));

    // R2
    acks_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (y_tick != $past(y_tick)) |-> ((a_ack != $past(a_ack)) && (b_ack != $past(b_ack))));

    // R9
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (y_tick == $past(y_tick)) |-> ($stable(y_prs) && $stable(y_val)));

    // R4
    when_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((y_tick != $past(y_tick)) && y_prs && ($past(mode) == 2'd0))
            |-> $past(a_prs && b_prs && b_val[0]));

    // R5
    merge_prs_chk: assert property (@(posedge clk) disable iff (rst)
        ((y_tick != $past(y_tick)) && ($past(mode) == 2'd1))
            |-> (y_prs == $past(a_prs || b_prs)));

endmodule

// File: tb/tb_stream_op_unit.sv
module tb_stream_op_unit;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [DW-1:0] a_val = '0, b_val = '0;
    logic          a_prs = 1'b0, b_prs = 1'b0;
    logic          a_tick = 1'b0, b_tick = 1'b0;
    logic          a_ack, b_ack, y_prs, y_tick;
    logic [DW-1:0] y_val;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [DW-1:0] hold_m = '0;

    always #5 clk = ~clk;

    stream_op_unit #(.DW(DW)) dut (
        .clk(clk), .rst(rst), .mode(mode),
        .a_val(a_val), .a_prs(a_prs), .a_tick(a_tick), .a_ack(a_ack),
        .b_val(b_val), .b_prs(b_prs), .b_tick(b_tick), .b_ack(b_ack),
        .y_val(y_val), .y_prs(y_prs), .y_tick(y_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_prs(input logic [1:0] m, input logic ap,
                                     input logic bp, input logic [DW-1:0] bv);
        case (m)
            2'd0:    return ap & bp & bv[0];
            2'd1:    return ap | bp;
            default: return ap;
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_val(input logic [1:0] m, input logic [DW-1:0] av,
                                              input logic ap, input logic [DW-1:0] bv,
                                              input logic [DW-1:0] hv);
        case (m)
            2'd1:    return ap ? av : bv;
            2'd2:    return hv;
            default: return av;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'd0:    return "R4";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // one instant: first = 0 toggles A first, 1 toggles B first, 2 both together
    task automatic instant(input logic [DW-1:0] av, input logic ap,
                           input logic [DW-1:0] bv, input logic bp,
                           input int first, input int gap);
        logic          t0, ya, yb, p0;
        logic [DW-1:0] v0, ev;
        logic          ep;
        t0 = y_tick; ya = a_ack; yb = b_ack; p0 = y_prs; v0 = y_val;
        a_val = av; a_prs = ap; b_val = bv; b_prs = bp;
        ep = exp_prs(mode, ap, bp, bv);
        ev = exp_val(mode, av, ap, bv, hold_m);
        if (first == 2) begin
            a_tick = ~a_tick; b_tick = ~b_tick;
        end else begin
            if (first == 0) a_tick = ~a_tick; else b_tick = ~b_tick;
            for (int g = 0; g <= gap; g++) begin
                @(negedge clk);
                // R3: one tick alone issues nothing
                chk(y_tick == t0 && a_ack == ya && b_ack == yb, "R3", int'(y_tick), int'(t0));
                // R9: result held between events
                chk(y_prs == p0 && y_val == v0, "R9", int'(y_val), int'(v0));
            end
            if (first == 0) b_tick = ~b_tick; else a_tick = ~a_tick;
        end
        @(negedge clk);
        chk(y_tick == ~t0, "R2 y_tick", int'(y_tick), int'(~t0));
        chk(a_ack == ~ya && b_ack == ~yb, "R2 acks", int'({a_ack, b_ack}), int'({~ya, ~yb}));
        chk(y_prs == ep, {req_of(mode), " prs"}, int'(y_prs), int'(ep));
        if (ep) chk(y_val == ev, {req_of(mode), " val"}, int'(y_val), int'(ev));
        if (ap) hold_m = av;
    endtask

    task automatic rnd_instant();
        instant(DW'($urandom), $urandom_range(0, 1) == 1, DW'($urandom),
                $urandom_range(0, 1) == 1, $urandom_range(0, 2), $urandom_range(0, 3));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state and no events while reset held
        a_tick = 1'b1; b_tick = 1'b1;
        @(negedge clk);
        chk(!y_tick && !a_ack && !b_ack && !y_prs, "R1", int'({y_tick, a_ack, b_ack, y_prs}), 0);
        a_tick = 1'b0; b_tick = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!y_tick && !a_ack && !b_ack, "R1 idle", int'({y_tick, a_ack, b_ack}), 0);

        // R6: delay right after reset yields 0, R10: absent still ticks
        mode = 2'd2;
        instant(8'h5A, 1'b1, 8'h00, 1'b0, 2, 0);
        instant(8'h11, 1'b0, 8'hFF, 1'b1, 0, 2);      // R10 absent result
        instant(8'h22, 1'b1, 8'h00, 1'b1, 1, 1);      // R8: carries 5A, not 11
        chk(y_val == 8'h5A, "R8", int'(y_val), 8'h5A);

        // R4 corners: condition present but false, condition absent
        mode = 2'd0;
        instant(8'h33, 1'b1, 8'h02, 1'b1, 0, 0);
        instant(8'h34, 1'b1, 8'h01, 1'b0, 1, 0);
        instant(8'h35, 1'b1, 8'h03, 1'b1, 2, 0);
        // R5 corners: both present, both absent, only B
        mode = 2'd1;
        instant(8'h40, 1'b1, 8'h41, 1'b1, 0, 1);
        instant(8'h42, 1'b0, 8'h43, 1'b0, 2, 0);      // R10
        instant(8'h44, 1'b0, 8'h45, 1'b1, 1, 2);

        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int k = 0; k < 60; k++) rnd_instant();
        end
        // R8: hold survives other modes, then read in delay mode
        mode = 2'd3;
        instant(8'hC3, 1'b1, 8'h00, 1'b1, 2, 0);
        mode = 2'd2;
        instant(8'h00, 1'b1, 8'h99, 1'b1, 2, 0);
        chk(y_val == 8'hC3, "R8 hold", int'(y_val), 8'hC3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule